// File: doc/BRIEF.md
# Single-Channel DMA Element Mover

This block is the data-moving core of a DMA controller. Once an arbiter has granted a channel, the block copies that channel's data one element at a time over a request/acknowledge bus master port. Each element takes two bus phases: a read from the source address, then a write to the destination address. Channel settings, arbitration and interrupt handling sit outside the block and reach it as plain inputs:

- the transfer direction;
- the memory-to-memory switch;
- the increment enables;
- the two element sizes;
- the two base addresses.

The block keeps two running pointers, one for the peripheral side and one for the memory side. When the controller pulses `addr_load` while the block is idle, both pointers take their base addresses. The source and destination are chosen as follows:

- With `dir_m2p` low and `mem_to_mem` low, the block reads from the peripheral pointer and writes to the memory pointer.
- If either switch is high, the roles swap.

The element read from the source is moved to the right byte lanes. It is taken from the source byte lanes, cut to the source size, and placed on the destination byte lanes with matching write strobes. After the write is acknowledged, each pointer whose increment enable is set advances by its own element size. A one-cycle `elem_done` pulse then marks the element as finished.

The controller is a Moore machine with six states:

| From | Condition | To |
|---|---|---|
| IDLE | `chan_valid` high | RD_REQ (start) |
| RD_REQ | always | RD_WAIT (issue) |
| RD_WAIT | `bus_ack` high | WR_REQ (read accepted) |
| WR_REQ | always | WR_WAIT (issue) |
| WR_WAIT | `bus_ack` high | DONE (write accepted) |
| DONE | always | IDLE (retire) |

RD_WAIT and WR_WAIT stay in place while `bus_ack` is low.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset the engine is in IDLE with `bus_req`, `bus_we`, `bus_wstrb` and `elem_done` all low. It leaves IDLE only in the cycle after a clock edge that samples `chan_valid` high. While idle, `bus_req` stays low.
- R2: A read phase drives `bus_req`=1, `bus_we`=0 and `bus_wstrb`=0000, and puts the source pointer on `bus_addr`. RD_REQ lasts exactly one cycle and is always followed by RD_WAIT. WR_REQ is likewise followed by WR_WAIT.
- R3: Each wait state is left only on a clock edge that samples `bus_ack` high; `bus_ack` is not looked at in any other state. While the engine waits, `bus_req` stays high and `bus_addr` stays stable.
- R4: The source and destination depend on the two switches:
  - `dir_m2p`=0 and `mem_to_mem`=0: the source is the peripheral pointer and the destination is the memory pointer.
  - `dir_m2p`=1 or `mem_to_mem`=1: the source is the memory pointer and the destination is the peripheral pointer.
- R5: The size codes are 00 = byte (1 byte), 01 = half-word (2 bytes) and 10 = word (4 bytes). Code 11 behaves as word.
- R6: The read data is captured on the read acknowledge. Before capture it is shifted right by 8×(source address bits [1:0]) and masked to the source size. During the write phase `bus_wdata` carries the captured value shifted left by 8×(destination address bits [1:0]).
- R7: During the write phase `bus_wstrb` is 0001, 0011 or 1111 for byte, half-word or word destination size, shifted left by the destination address bits [1:0] and cut to 4 bits.
- R8: In DONE each pointer advances by its own size in bytes (1, 2 or 4) if its increment enable is set, and otherwise keeps its value.
- R9: `elem_done` is high for exactly the one cycle spent in DONE. `bus_req` is low in that cycle, and IDLE follows.
- R10: `addr_load` sampled high while in IDLE copies `per_base` and `mem_base` into the two pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_valid | input | 1 | A granted channel is ready for the next element |
| addr_load | input | 1 | Copy the base addresses into the pointers (IDLE only) |
| dir_m2p | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| mem_to_mem | input | 1 | Memory-to-memory copy; read the memory pointer, write the peripheral pointer |
| per_inc | input | 1 | Advance the peripheral pointer after each element |
| mem_inc | input | 1 | Advance the memory pointer after each element |
| per_size | input | 2 | Peripheral element size code |
| mem_size | input | 2 | Memory element size code |
| per_base | input | 32 | Peripheral base address |
| mem_base | input | 32 | Memory base address |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 for a write phase, 0 for a read phase |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 32 | Write data, lane-aligned |
| bus_wstrb | output | 4 | Write byte strobes |
| bus_rdata | input | 32 | Read data |
| bus_ack | input | 1 | Bus acknowledge |
| elem_done | output | 1 | One-cycle pulse when an element completes |

## Verification
All outputs are decoded directly from the state register, so a wrong state shows at the ports in the same cycle. Examples:
- a skipped wait state drops or flips `bus_we` one cycle early;
- a stuck DONE holds `elem_done` high for a second cycle.

A pointer that steps wrongly, or a mixed-up source/destination choice, shows up as a wrong `bus_addr` in the read phase of the very next element. A lane-alignment fault shows on `bus_wdata` or `bus_wstrb` in the write request that follows the read acknowledge.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_DONE
    } xfer_state_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    // log2 of the element size in bytes; the spare code maps to word
    function automatic logic [1:0] size_log2(input logic [1:0] code);
        logic [1:0] r;
        case (code)
            SZ_BYTE: r = 2'd0;
            SZ_HALF: r = 2'd1;
            default: r = 2'd2;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_xfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        chan_valid,
    input  logic        bus_ack,
    output xfer_state_e state,
    output logic        req,
    output logic        we,
    output logic        capture,
    output logic        done
);

    xfer_state_e state_q;
    xfer_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (chan_valid) state_d = ST_RD_REQ;
            ST_RD_REQ:  state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (bus_ack) state_d = ST_WR_REQ;
            ST_WR_REQ:  state_d = ST_WR_WAIT;
            ST_WR_WAIT: if (bus_ack) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req     = 1'b0;
        we      = 1'b0;
        capture = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD_REQ: req = 1'b1;
            ST_RD_WAIT: begin
                req     = 1'b1;
                capture = bus_ack;
            end
            ST_WR_REQ: begin
                req = 1'b1;
                we  = 1'b1;
            end
            ST_WR_WAIT: begin
                req = 1'b1;
                we  = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign state = state_q;

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !chan_valid) |=> (state_q == ST_IDLE));

    assert_rdreq_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_REQ) |=> (state_q == ST_RD_WAIT));

    assert_wrreq_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_REQ) |=> (state_q == ST_WR_WAIT));

    assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RD_WAIT || state_q == ST_WR_WAIT) && !bus_ack) |=> $stable(state_q));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && state_q == ST_IDLE));

endmodule

// File: rtl/dma_addr_track.sv
module dma_addr_track
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] per_base,
    input  logic [ADDR_W-1:0] mem_base,
    input  logic              per_inc,
    input  logic              mem_inc,
    input  logic [1:0]        per_size,
    input  logic [1:0]        mem_size,
    output logic [ADDR_W-1:0] per_ptr,
    output logic [ADDR_W-1:0] mem_ptr
);

    localparam int SIDES = 2;

    logic [SIDES-1:0][ADDR_W-1:0] base;
    logic [SIDES-1:0][ADDR_W-1:0] ptr_q;
    logic [SIDES-1:0]             inc;
    logic [SIDES-1:0][1:0]        size;

    assign base = {mem_base, per_base};
    assign inc  = {mem_inc, per_inc};
    assign size = {mem_size, per_size};

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        logic [ADDR_W-1:0] stride;
        assign stride = ADDR_W'(1) << size_log2(size[g]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            ptr_q[g] <= '0;
            else if (load)         ptr_q[g] <= base[g];
            else if (step && inc[g]) ptr_q[g] <= ptr_q[g] + stride;
        end

        assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!load && !(step && inc[g])) |=> $stable(ptr_q[g]));
    end

    assign per_ptr = ptr_q[0];
    assign mem_ptr = ptr_q[1];

endmodule

// File: rtl/dma_lane_unit.sv
module dma_lane_unit
    import dma_xfer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      capture,
    input  logic [DATA_W-1:0]         rdata,
    input  logic [$clog2(DATA_W/8)-1:0] src_lo,
    input  logic [1:0]                src_size,
    input  logic [$clog2(DATA_W/8)-1:0] dst_lo,
    input  logic [1:0]                dst_size,
    output logic [DATA_W-1:0]         wdata,
    output logic [DATA_W/8-1:0]       wstrb
);

    localparam int LANES = DATA_W / 8;
    localparam int LO_W  = $clog2(LANES);
    localparam int SH_W  = LO_W + 3;

    logic [DATA_W-1:0]  hold_q;
    logic [DATA_W-1:0]  mask;
    logic [DATA_W-1:0]  extracted;
    logic [SH_W-1:0]    src_sh;
    logic [SH_W-1:0]    dst_sh;
    logic [LANES-1:0]   base_strb;
    logic [2*LANES-1:0] wide_strb;

    assign src_sh = {src_lo, 3'b000};
    assign dst_sh = {dst_lo, 3'b000};

    always_comb begin
        case (size_log2(src_size))
            2'd0:    mask = DATA_W'(8'hFF);
            2'd1:    mask = DATA_W'(16'hFFFF);
            default: mask = '1;
        endcase
        extracted = (rdata >> src_sh) & mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hold_q <= '0;
        else if (capture) hold_q <= extracted;
    end

    always_comb begin
        case (size_log2(dst_size))
            2'd0:    base_strb = LANES'(1);
            2'd1:    base_strb = LANES'(3);
            default: base_strb = '1;
        endcase
        wide_strb = {{LANES{1'b0}}, base_strb} << dst_lo;
    end

    assign wdata = hold_q << dst_sh;
    assign wstrb = wide_strb[LANES-1:0];

    assert_hold_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(hold_q));

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_valid,
    input  logic              addr_load,
    input  logic              dir_m2p,
    input  logic              mem_to_mem,
    input  logic              per_inc,
    input  logic              mem_inc,
    input  logic [1:0]        per_size,
    input  logic [1:0]        mem_size,
    input  logic [ADDR_W-1:0] per_base,
    input  logic [ADDR_W-1:0] mem_base,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W/8-1:0] bus_wstrb,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              elem_done
);

    localparam int LANES = DATA_W / 8;
    localparam int LO_W  = $clog2(LANES);

    xfer_state_e       state;
    logic              req;
    logic              we;
    logic              capture;
    logic              done;
    logic [ADDR_W-1:0] per_ptr;
    logic [ADDR_W-1:0] mem_ptr;
    logic              src_is_mem;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
    logic [1:0]        src_size;
    logic [1:0]        dst_size;
    logic [DATA_W-1:0] lane_wdata;
    logic [LANES-1:0]  lane_wstrb;

    dma_xfer_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_valid (chan_valid),
        .bus_ack    (bus_ack),
        .state      (state),
        .req        (req),
        .we         (we),
        .capture    (capture),
        .done       (done)
    );

    dma_addr_track #(.ADDR_W(ADDR_W)) i_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_load && state == ST_IDLE),
        .step     (done),
        .per_base (per_base),
        .mem_base (mem_base),
        .per_inc  (per_inc),
        .mem_inc  (mem_inc),
        .per_size (per_size),
        .mem_size (mem_size),
        .per_ptr  (per_ptr),
        .mem_ptr  (mem_ptr)
    );

    assign src_is_mem = dir_m2p | mem_to_mem;
    assign src_addr   = src_is_mem ? mem_ptr  : per_ptr;
    assign dst_addr   = src_is_mem ? per_ptr  : mem_ptr;
    assign src_size   = src_is_mem ? mem_size : per_size;
    assign dst_size   = src_is_mem ? per_size : mem_size;

    dma_lane_unit #(.DATA_W(DATA_W)) i_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .rdata    (bus_rdata),
        .src_lo   (src_addr[LO_W-1:0]),
        .src_size (src_size),
        .dst_lo   (dst_addr[LO_W-1:0]),
        .dst_size (dst_size),
        .wdata    (lane_wdata),
        .wstrb    (lane_wstrb)
    );

    assign bus_req   = req;
    assign bus_we    = we;
    assign bus_addr  = we ? dst_addr : src_addr;
    assign bus_wdata = we ? lane_wdata : '0;
    assign bus_wstrb = we ? lane_wstrb : '0;
    assign elem_done = done;

    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && (state == ST_RD_WAIT || state == ST_WR_WAIT))
            |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    assert_read_nostrb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |-> (bus_wstrb == '0));

    assert_write_strb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> ($countones(bus_wstrb) >= 1));

    assert_done_noreq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        elem_done |-> !bus_req);

endmodule

// File: tb/test_dma_xfer_engine.sv
module test_dma_xfer_engine;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_valid = 1'b0;
    logic        addr_load = 1'b0;
    logic        dir_m2p = 1'b0;
    logic        mem_to_mem = 1'b0;
    logic        per_inc = 1'b0;
    logic        mem_inc = 1'b0;
    logic [1:0]  per_size = 2'b10;
    logic [1:0]  mem_size = 2'b10;
    logic [31:0] per_base = '0;
    logic [31:0] mem_base = '0;
    logic        bus_req;
    logic        bus_we;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_wstrb;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        elem_done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_xfer_engine i_dma_xfer_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_valid (chan_valid),
        .addr_load  (addr_load),
        .dir_m2p    (dir_m2p),
        .mem_to_mem (mem_to_mem),
        .per_inc    (per_inc),
        .mem_inc    (mem_inc),
        .per_size   (per_size),
        .mem_size   (mem_size),
        .per_base   (per_base),
        .mem_base   (mem_base),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wstrb  (bus_wstrb),
        .bus_rdata  (bus_rdata),
        .bus_ack    (bus_ack),
        .elem_done  (elem_done)
    );

    typedef struct packed {
        logic        dir;
        logic        m2m;
        logic [1:0]  ps;
        logic [1:0]  ms;
        logic [31:0] pb;
        logic [31:0] mb;
        logic [31:0] rd;
        logic [31:0] ra;
        logic [31:0] wa;
        logic [31:0] wd;
        logic [3:0]  st;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 2'b10, 2'b10, 32'h1000_0000, 32'h2000_0000, 32'hDEAD_BEEF,
          32'h1000_0000, 32'h2000_0000, 32'hDEAD_BEEF, 4'b1111},
        '{1'b1, 1'b0, 2'b10, 2'b10, 32'h1000_0008, 32'h2000_0004, 32'h1234_5678,
          32'h2000_0004, 32'h1000_0008, 32'h1234_5678, 4'b1111},
        '{1'b0, 1'b0, 2'b00, 2'b00, 32'h1000_0001, 32'h2000_0003, 32'hAABB_CCDD,
          32'h1000_0001, 32'h2000_0003, 32'hCC00_0000, 4'b1000},
        '{1'b1, 1'b0, 2'b01, 2'b01, 32'h1000_0000, 32'h2000_0002, 32'h1122_3344,
          32'h2000_0002, 32'h1000_0000, 32'h0000_1122, 4'b0011},
        '{1'b0, 1'b1, 2'b00, 2'b10, 32'h4000_0002, 32'h3000_0000, 32'h5566_7788,
          32'h3000_0000, 32'h4000_0002, 32'h7788_0000, 4'b0100},
        '{1'b0, 1'b0, 2'b11, 2'b00, 32'h5000_0000, 32'h6000_0001, 32'hCAFE_F00D,
          32'h5000_0000, 32'h6000_0001, 32'hFEF0_0D00, 4'b0010}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_ptrs(input logic [31:0] pb, input logic [31:0] mb);
        per_base  = pb;
        mem_base  = mb;
        addr_load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        addr_load = 1'b0;
    endtask

    // Runs one element from IDLE; called and returns at a falling edge.
    task automatic run_elem(input logic [31:0] ra, input logic [31:0] wa,
                            input logic [31:0] rd, input logic [31:0] wd,
                            input logic [3:0] st, input int stall);
        chan_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chan_valid = 1'b0;
        chk("R2 read req", {30'd0, bus_req, bus_we}, 32'd2);
        chk("R4 read addr", bus_addr, ra);
        chk("R2 read strb", {28'd0, bus_wstrb}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < stall; k++) begin
            chk("R3 read wait req", {31'd0, bus_req}, 32'd1);
            chk("R3 read wait addr", bus_addr, ra);
            @(posedge clk);
            @(negedge clk);
        end
        bus_rdata = rd;
        bus_ack   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_ack   = 1'b0;
        bus_rdata = 32'h5A5A_5A5A;
        chk("R2 write req", {30'd0, bus_req, bus_we}, 32'd3);
        chk("R4 write addr", bus_addr, wa);
        chk("R6 write data", bus_wdata, wd);
        chk("R7 write strb", {28'd0, bus_wstrb}, {28'd0, st});
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < stall; k++) begin
            chk("R3 write wait", {30'd0, bus_req, bus_we}, 32'd3);
            chk("R3 write wait addr", bus_addr, wa);
            @(posedge clk);
            @(negedge clk);
        end
        bus_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_ack = 1'b0;
        chk("R9 done pulse", {30'd0, elem_done, bus_req}, 32'd2);
        @(posedge clk);
        @(negedge clk);
        chk("R9 back to idle", {30'd0, elem_done, bus_req}, 32'd0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset outputs", {26'd0, bus_req, bus_we, bus_wstrb, elem_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: no start without a valid channel
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R1 idle no req", {31'd0, bus_req}, 32'd0);
        end

        // Table walk: R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            dir_m2p    = VECS[v].dir;
            mem_to_mem = VECS[v].m2m;
            per_size   = VECS[v].ps;
            mem_size   = VECS[v].ms;
            per_inc    = 1'b0;
            mem_inc    = 1'b0;
            load_ptrs(VECS[v].pb, VECS[v].mb);
            run_elem(VECS[v].ra, VECS[v].wa, VECS[v].rd, VECS[v].wd, VECS[v].st, v % 2);
        end

        // R8 R10: peripheral half-word stepping, memory fixed, with a long stall
        dir_m2p = 1'b0; mem_to_mem = 1'b0;
        per_inc = 1'b1; mem_inc = 1'b0;
        per_size = 2'b01; mem_size = 2'b10;
        load_ptrs(32'h0000_0100, 32'h0000_0200);
        run_elem(32'h100, 32'h200, 32'h0000_ABCD, 32'h0000_ABCD, 4'b1111, 0);
        run_elem(32'h102, 32'h200, 32'h1234_0000, 32'h0000_1234, 4'b1111, 0);
        run_elem(32'h104, 32'h200, 32'h0000_BEEF, 32'h0000_BEEF, 4'b1111, 3);

        // R8 R5: memory byte stepping, peripheral code 11 stepping by four
        dir_m2p = 1'b1;
        per_inc = 1'b1; mem_inc = 1'b1;
        per_size = 2'b11; mem_size = 2'b00;
        load_ptrs(32'h0000_0400, 32'h0000_0203);
        run_elem(32'h203, 32'h400, 32'h9A00_0000, 32'h0000_009A, 4'b1111, 0);
        run_elem(32'h204, 32'h404, 32'h0000_0077, 32'h0000_0077, 4'b1111, 1);

        // R1: idle again after the last element
        repeat (2) @(negedge clk);
        chk("R1 idle after run", {31'd0, bus_req}, 32'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule